// File: doc/BRIEF.md
# Fast-to-Peripheral Bus Bridge

The bridge is a slave on a fast processor-side bus. It forwards single-beat reads and writes to a slower peripheral bus. It claims a 32 KB window of the processor address map, which is selected by a base-address parameter, and splits that window into equal slots, one slot per peripheral module. Two parameter masks set which slots hold a real module and which of those modules have a 32-bit bus interface. The other modules have a 16-bit interface.

A 32-bit access to a wide module becomes one peripheral strobe. A 32-bit access to a narrow module becomes two strobes. The upper halfword goes first, at the word address. The lower halfword follows at the word address plus two. For a read, the two halves are rebuilt into one word before the acknowledge. A mode input runs the peripheral side at the processor rate or at half of it; at half rate every strobe spans two processor clocks. A burst request, a misaligned address or an address in an empty slot gets a one-cycle error response, and no peripheral strobe is issued. Requests outside the window get no response.

Top module: `pbus_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, `p_stb`, `p_sel`, `resp_ack` and `resp_err` are all low.
- R2: A request whose address bits [31:15] differ from the window base gets no acknowledge, no error and no strobe.
- R3: An aligned single request to a wide module gives exactly one strobe at the word address. The strobe carries all 32 write bits, and a read returns all 32 read bits.
- R4: A request to a narrow module gives two strobes. The first is at the word address and carries bits [31:16] on `p_wdata[15:0]`. The second is at word address + 2 and carries bits [15:0]. A read returns {first `p_rdata[15:0]`, second `p_rdata[15:0]`}.
- R5: Peripheral strobes rise and fall only on enabled cycles. With `half_rate` low every cycle is enabled. With `half_rate` high, only the odd-numbered clock edges after reset release (edge 0 being the first) are enabled, so each strobe lasts two cycles.
- R6: A request to a slot whose bit in IMPL_MASK is 0 ends in an error response with no strobe.
- R7: A request with `req_burst` high ends in an error response with no strobe, even when it also targets an empty slot.
- R8: `resp_ack` and `resp_err` are never high together, each lasts exactly one cycle, and `resp_rdata` holds the read word while `resp_ack` is high for a read.
- R9: While `p_stb` is high, `p_sel` is one-hot on the slot given by address bits [14:12]. While `p_stb` is low, `p_sel` is zero.
- R10: A request whose address bits [1:0] are not zero ends in an error response with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Active-low system soft reset |
| half_rate | input | 1 | 1: peripheral side paced at half the processor rate |
| req_valid | input | 1 | Request held until a response is returned |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Request asks for a burst (refused) |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| resp_ack | output | 1 | One-cycle transfer acknowledge |
| resp_err | output | 1 | One-cycle transfer error |
| resp_rdata | output | 32 | Read word, valid with `resp_ack` |
| p_stb | output | 1 | Peripheral transfer strobe |
| p_sel | output | 8 | One-hot module select |
| p_write | output | 1 | Peripheral write flag, high only with `p_stb` |
| p_addr | output | 15 | Byte offset inside the window |
| p_wdata | output | 32 | Peripheral write data |
| p_rdata | input | 32 | Peripheral read data, sampled at the end of a strobe |

## Verification
The error path has three causes, and two of them can apply to the same request. A burst can also land on an empty slot. The bench sends exactly that request, a burst read to the last empty slot. It expects a single one-cycle error, with no strobe and no second response.

The pacing mode can also change while a narrow split is in flight. The bench flips `half_rate` a few cycles into a two-beat read. Its per-cycle reference model recomputes the enabled cycles on every edge, so the strobe edges, the halfword order and the rebuilt read word are all judged against the new pacing.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_STROBE = 2'd2,
        ST_RESP   = 2'd3
    } bridge_state_e;
endpackage

// File: rtl/pbb_decode.sv
module pbb_decode #(
    parameter int ADDR_W    = 32,
    parameter int WIN_BITS  = 15,
    parameter int SLOT_BITS = 3,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0030_0000,
    parameter logic [(1<<SLOT_BITS)-1:0] IMPL_MASK = 8'b0111_1011,
    parameter logic [(1<<SLOT_BITS)-1:0] WIDE_MASK = 8'b0001_0011
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 in_win_o,
    output logic                 aligned_o,
    output logic [SLOT_BITS-1:0] slot_o,
    output logic                 impl_o,
    output logic                 wide_o
);
    always_comb begin
        in_win_o  = (addr_i[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
        aligned_o = (addr_i[1:0] == 2'b00);
        slot_o    = addr_i[WIN_BITS-1 -: SLOT_BITS];
        impl_o    = IMPL_MASK[slot_o];
        wide_o    = WIDE_MASK[slot_o];
    end
endmodule

// File: rtl/pbb_pace.sv
module pbb_pace (
    input  logic clk,
    input  logic rst_n,
    input  logic half_rate_i,
    output logic tick_o
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = ~phase_q;
        tick_o  = ~half_rate_i | phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    // R5
    half_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_rate_i && tick_o |=> !half_rate_i || !tick_o);
endmodule

// File: rtl/pbb_steer.sv
module pbb_steer #(
    parameter int WIN_BITS = 15,
    parameter int DATA_W   = 32
) (
    input  logic [WIN_BITS-3:0]   waddr_i,
    input  logic                  beat_i,
    input  logic                  wide_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [DATA_W/2-1:0]   upper_i,
    input  logic [DATA_W-1:0]     rdata_i,
    output logic [WIN_BITS-1:0]   p_addr_o,
    output logic [DATA_W-1:0]     p_wdata_o,
    output logic [DATA_W-1:0]     word_o
);
    localparam int HALF_W = DATA_W / 2;

    logic second_half;

    always_comb begin
        second_half = beat_i & ~wide_i;
        p_addr_o    = {waddr_i, second_half, 1'b0};
        if (wide_i)
            p_wdata_o = wdata_i;
        else if (beat_i)
            p_wdata_o = {{HALF_W{1'b0}}, wdata_i[HALF_W-1:0]};
        else
            p_wdata_o = {{HALF_W{1'b0}}, wdata_i[DATA_W-1:HALF_W]};
        word_o = wide_i ? rdata_i : {upper_i, rdata_i[HALF_W-1:0]};
    end
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
    import pbb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int WIN_BITS  = 15,
    parameter int SLOT_BITS = 3,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0030_0000,
    parameter logic [(1<<SLOT_BITS)-1:0] IMPL_MASK = 8'b0111_1011,
    parameter logic [(1<<SLOT_BITS)-1:0] WIDE_MASK = 8'b0001_0011
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      half_rate,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_burst,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      resp_ack,
    output logic                      resp_err,
    output logic [DATA_W-1:0]         resp_rdata,
    output logic                      p_stb,
    output logic [(1<<SLOT_BITS)-1:0] p_sel,
    output logic                      p_write,
    output logic [WIN_BITS-1:0]       p_addr,
    output logic [DATA_W-1:0]         p_wdata,
    input  logic [DATA_W-1:0]         p_rdata
);
    localparam int NSLOT   = 1 << SLOT_BITS;
    localparam int HALF_W  = DATA_W / 2;
    localparam int WADDR_W = WIN_BITS - 2;

    typedef struct packed {
        bridge_state_e           state;
        logic                    beat;
        logic                    wide;
        logic                    write;
        logic [WADDR_W-1:0]      waddr;
        logic [SLOT_BITS-1:0]    slot;
        logic [DATA_W-1:0]       wdata;
        logic [HALF_W-1:0]       upper;
        logic [DATA_W-1:0]       rdata;
        logic                    stb;
        logic                    ack;
        logic                    err;
    } bridge_regs_t;

    localparam bridge_regs_t RESET_VAL = '0;

    bridge_regs_t r_d, r_q;

    logic                 dec_in_win, dec_aligned, dec_impl, dec_wide;
    logic [SLOT_BITS-1:0] dec_slot;
    logic                 tick;
    logic [DATA_W-1:0]    built_word;

    pbb_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .SLOT_BITS(SLOT_BITS),
        .WIN_BASE (WIN_BASE),
        .IMPL_MASK(IMPL_MASK),
        .WIDE_MASK(WIDE_MASK)
    ) u_decode (
        .addr_i   (req_addr),
        .in_win_o (dec_in_win),
        .aligned_o(dec_aligned),
        .slot_o   (dec_slot),
        .impl_o   (dec_impl),
        .wide_o   (dec_wide)
    );

    pbb_pace u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_rate_i(half_rate),
        .tick_o     (tick)
    );

    pbb_steer #(
        .WIN_BITS(WIN_BITS),
        .DATA_W  (DATA_W)
    ) u_steer (
        .waddr_i  (r_q.waddr),
        .beat_i   (r_q.beat),
        .wide_i   (r_q.wide),
        .wdata_i  (r_q.wdata),
        .upper_i  (r_q.upper),
        .rdata_i  (p_rdata),
        .p_addr_o (p_addr),
        .p_wdata_o(p_wdata),
        .word_o   (built_word)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        r_d.err = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid && dec_in_win) begin
                    r_d.waddr = req_addr[WIN_BITS-1:2];
                    r_d.slot  = dec_slot;
                    r_d.wide  = dec_wide;
                    r_d.write = req_write;
                    r_d.wdata = req_wdata;
                    r_d.beat  = 1'b0;
                    if (req_burst || !dec_impl || !dec_aligned) begin
                        r_d.err   = 1'b1;
                        r_d.state = ST_RESP;
                    end else begin
                        r_d.state = ST_LAUNCH;
                    end
                end
            end
            ST_LAUNCH: begin
                if (tick) begin
                    r_d.stb   = 1'b1;
                    r_d.state = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (tick) begin
                    r_d.stb = 1'b0;
                    if (!r_q.wide && !r_q.beat) begin
                        r_d.upper = p_rdata[HALF_W-1:0];
                        r_d.beat  = 1'b1;
                        r_d.state = ST_LAUNCH;
                    end else begin
                        r_d.ack   = 1'b1;
                        r_d.state = ST_RESP;
                        if (!r_q.write) r_d.rdata = built_word;
                    end
                end
            end
            ST_RESP: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_sel
        assign p_sel[gi] = r_q.stb && (r_q.slot == SLOT_BITS'(gi));
    end

    assign p_stb      = r_q.stb;
    assign p_write    = r_q.stb & r_q.write;
    assign resp_ack   = r_q.ack;
    assign resp_err   = r_q.err;
    assign resp_rdata = r_q.rdata;

    // R8
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_ack && resp_err));
    // R8
    resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ack || resp_err) |=> !(resp_ack || resp_err));
    // R9
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_stb |-> $countones(p_sel) == 1);
    // R9
    sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p_stb |-> p_sel == '0);
    // R5
    stb_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_stb != $past(p_stb)) |-> $past(tick));
    // R4
    stb_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_stb && $past(p_stb) |-> $stable(p_addr));
    // R7
    burst_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && req_valid && dec_in_win && req_burst)
        |=> resp_err && !p_stb);
    // R10
    misalign_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && req_valid && dec_in_win && req_addr[1:0] != 2'b00)
        |=> resp_err && !p_stb);
    // R6
    err_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> !p_stb);
endmodule

// File: tb/pbus_bridge_test.sv
module pbus_bridge_test;
    localparam logic [31:0] BASE = 32'h0030_0000;
    localparam logic [7:0]  IMPL = 8'b0111_1011;
    localparam logic [7:0]  WIDE = 8'b0001_0011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_rate = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        resp_ack, resp_err, p_stb, p_write;
    logic [31:0] resp_rdata, p_wdata, p_rdata;
    logic [7:0]  p_sel;
    logic [14:0] p_addr;

    int nchk = 0, nfail = 0;
    int stb_rises = 0;
    logic prev_stb = 1'b0;
    bit  run = 1'b0;

    always #10 clk = ~clk;

    pbus_bridge uut (
        .clk(clk), .rst_n(rst_n), .half_rate(half_rate),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_ack(resp_ack), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .p_stb(p_stb), .p_sel(p_sel), .p_write(p_write), .p_addr(p_addr),
        .p_wdata(p_wdata), .p_rdata(p_rdata)
    );

    function automatic logic [31:0] mod_word(input logic [14:0] a);
        return {a ^ 15'h02A5, 1'b1, a, 1'b0};
    endfunction

    assign p_rdata = WIDE[p_addr[14:12]] ? mod_word(p_addr)
                                         : {16'hDEAD, mod_word(p_addr)[15:0]};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: stage codes, cycle parity, precomputed results
    int          m_stage = 0, m_cyc = 0;
    bit          m_beat, m_wide, m_wr;
    int          m_slot;
    logic [14:0] m_base;
    logic [31:0] m_wd, m_rd_exp;
    bit          e_stb, e_ack, e_err;
    logic [31:0] e_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stage = 0; m_cyc = 0; e_stb = 0; e_ack = 0; e_err = 0; e_rdata = '0;
        end else begin
            bit en;
            en = !half_rate || (m_cyc % 2 == 1);
            m_cyc++;
            e_ack = 0; e_err = 0;
            case (m_stage)
                0: if (req_valid && req_addr[31:15] == BASE[31:15]) begin
                    m_base = {req_addr[14:2], 2'b00};
                    m_slot = int'(req_addr[14:12]);
                    m_wide = WIDE[m_slot];
                    m_wr   = req_write;
                    m_wd   = req_wdata;
                    m_beat = 0;
                    m_rd_exp = m_wide ? mod_word(m_base)
                             : {mod_word(m_base)[15:0], mod_word(m_base + 15'd2)[15:0]};
                    if (req_burst || !IMPL[m_slot] || req_addr[1:0] != 2'b00) begin
                        e_err = 1; m_stage = 3;
                    end else m_stage = 1;
                end
                1: if (en) begin e_stb = 1; m_stage = 2; end
                2: if (en) begin
                    e_stb = 0;
                    if (!m_wide && !m_beat) begin m_beat = 1; m_stage = 1; end
                    else begin
                        e_ack = 1; m_stage = 3;
                        if (!m_wr) e_rdata = m_rd_exp;
                    end
                end
                default: m_stage = 0;
            endcase
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #5;
        if (run) begin
            chk("R8 resp_ack", 32'(resp_ack), 32'(e_ack));
            chk("R6/R7/R10 resp_err", 32'(resp_err), 32'(e_err));
            chk("R5 p_stb", 32'(p_stb), 32'(e_stb));
            if (e_stb) begin
                chk("R9 p_sel", 32'(p_sel), 32'(8'(1 << m_slot)));
                chk("R3/R4 p_addr", 32'(p_addr),
                    32'(m_base | ((m_beat && !m_wide) ? 15'd2 : 15'd0)));
                chk("R3/R4 p_write", 32'(p_write), 32'(m_wr));
                if (m_wr)
                    chk("R3/R4 p_wdata", p_wdata,
                        m_wide ? m_wd : (m_beat ? {16'h0, m_wd[15:0]} : {16'h0, m_wd[31:16]}));
            end else begin
                chk("R9 p_sel idle", 32'(p_sel), 32'h0);
            end
            if (e_ack && !m_wr) chk("R8 resp_rdata", resp_rdata, e_rdata);
            if (p_stb && !prev_stb) stb_rises++;
            prev_stb = p_stb;
        end
    end

    task automatic xfer(input logic [31:0] a, input bit w, input bit b,
                        input logic [31:0] wd, input int exp_stb,
                        input bit exp_resp, input string tag);
        bit got;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = w; req_burst = b; req_wdata = wd;
        stb_rises = 0;
        got = 0;
        if (exp_resp) begin
            for (int i = 0; i < 40 && !got; i++) begin
                @(posedge clk); #5;
                if (resp_ack || resp_err) got = 1;
            end
        end else begin
            for (int i = 0; i < 8; i++) begin
                @(posedge clk); #5;
                if (resp_ack || resp_err) got = 1;
            end
        end
        @(negedge clk);
        req_valid = 0; req_burst = 0;
        chk({tag, " response seen"}, 32'(got), 32'(exp_resp));
        chk({tag, " strobe count"}, 32'(stb_rises), 32'(exp_stb));
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] sa(input int slot, input int off);
        return BASE + 32'(slot * 4096 + off);
    endfunction

    initial begin
        #200000000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1 stb in reset", 32'(p_stb), 0);
        chk("R1 sel in reset", 32'(p_sel), 0);
        chk("R1 resp in reset", 32'({resp_ack, resp_err}), 0);
        rst_n = 1;
        run = 1;
        @(posedge clk); #5;
        chk("R1 stb after release", 32'(p_stb), 0);
        chk("R1 resp after release", 32'({resp_ack, resp_err}), 0);

        for (int pass = 0; pass < 2; pass++) begin
            @(negedge clk); half_rate = (pass == 1);
            xfer(sa(0, 32'h10), 0, 0, 0, 1, 1, "R3 wide read");
            xfer(sa(1, 32'h24), 1, 0, 32'hCAFE_F00D, 1, 1, "R3 wide write");
            xfer(sa(3, 32'h40), 0, 0, 0, 2, 1, "R4 narrow read");
            xfer(sa(5, 32'h7C), 1, 0, 32'h1234_ABCD, 2, 1, "R4 narrow write");
            xfer(sa(6, 32'hFFC), 0, 0, 0, 2, 1, "R4 narrow read top");
            xfer(sa(2, 32'h08), 0, 0, 0, 0, 1, "R6 empty slot");
            xfer(sa(0, 32'h08), 0, 1, 0, 0, 1, "R7 burst");
            xfer(sa(7, 32'h00), 0, 1, 0, 0, 1, "R7 burst to empty slot");
            xfer(sa(4, 32'h02), 1, 0, 32'h5555_AAAA, 0, 1, "R10 misaligned");
            xfer(32'h0040_0010, 0, 0, 0, 0, 0, "R2 outside window");
        end

        // R5: pacing switched while a narrow split is in flight
        fork
            begin repeat (3) @(negedge clk); half_rate = 1'b0; end
        join_none
        xfer(sa(3, 32'h200), 0, 0, 0, 2, 1, "R5 rate flip mid split");
        fork
            begin repeat (4) @(negedge clk); half_rate = 1'b1; end
        join_none
        xfer(sa(5, 32'h300), 1, 0, 32'h0F0F_F0F0, 2, 1, "R5 rate flip write split");
        xfer(sa(4, 32'h44), 0, 0, 0, 1, 1, "R3 wide read half");

        run = 0;
        $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule